// File: doc/BRIEF.md
# Masked multicast destination address filter

This block decides, for each received Ethernet frame, whether its 48-bit destination address falls inside one of a bank of programmable address windows. Each window is an entry made of a 48-bit address and a 48-bit compare mask. A mask bit of 1 makes the matching address bit take part in the comparison, and a mask bit of 0 makes it a don't-care. One entry can therefore cover a block of consecutive multicast addresses. A frame is accepted when at least one enabled entry matches.

Software programs the bank through a write-only word bus on the host clock. The match logic runs on the receive clock and watches a byte stream with start-of-frame and end-of-frame markers. Only the per-entry enable bits pass through two-flop synchronizers. Address and mask values reach the receive domain unsynchronized, and each entry's values are forced to zero while that entry's synchronized enable is low. Software changes an entry safely in three steps: clear its enable bit, rewrite its address and mask words, then set the enable bit again. The decision is a one-cycle pulse on the receive clock.

Top module: `mcf_dst_filter`

## Requirements
- R1: After reset every register reads as zero and every entry is disabled. `dec_valid` is low, and every frame then gets a reject decision.
- R2: Word 0 is the enable register, and bit n enables entry n. Entry n occupies words 1+4n to 4+4n: address low, address high (bits [15:0]), mask low, then mask high (bits [15:0]).
- R3: The 48-bit address is formed from the first two destination bytes as the high part (the first byte in bits [15:8]) and the next four bytes as the low part (the third byte in bits [31:24]). A full mask accepts only an exact match, so a one-bit difference is rejected.
- R4: A mask bit of 0 excludes that address bit from the comparison. A low mask of 0xFFFF_FFF0 accepts all 16 addresses that differ only in bits [3:0], and an all-zero mask accepts any address.
- R5: A frame is accepted when any enabled entry matches, whichever entry index that is.
- R6: A disabled entry never matches, even when its programmed address and mask would.
- R7: The decision is one `dec_valid` pulse on the receive-clock edge that samples the sixth destination byte plus one register stage. `dec_accept` is high only together with `dec_valid`.
- R8: A frame whose end-of-frame byte (a byte taken with `rx_valid`) comes before the sixth byte produces exactly one reject pulse on the edge after that byte is sampled. This includes a one-byte frame.
- R9: Bytes after the sixth have no effect: each frame produces exactly one decision pulse, whatever its length.
- R10: A start-of-frame byte restarts the byte count, even when the previous frame has neither ended nor reached six bytes.
- R11: Enable changes reach the receive domain through a two-flop synchronizer. After the disable, rewrite and re-enable sequence, the new address matches and the old address does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host register clock |
| host_rst_n | input | 1 | Asynchronous active-low reset for the host domain |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Word index of the register being written |
| reg_wdata | input | 32 | Write data |
| rx_clk | input | 1 | Receive byte clock |
| rx_rst_n | input | 1 | Asynchronous active-low reset for the receive domain |
| rx_valid | input | 1 | A byte is present on `rx_data` |
| rx_sof | input | 1 | Marks the first byte of a frame; used only when `rx_valid` is high |
| rx_eof | input | 1 | Marks the last byte of a frame; used only when `rx_valid` is high |
| rx_data | input | 8 | Received byte |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | High when the frame is accepted; valid together with `dec_valid` |

## Verification
Each possible internal fault shows up at the decision outputs within one frame.
- A wrong byte counter moves the `dec_valid` pulse off the cycle after the sixth byte, adds a pulse, or drops one.
- A wrong byte order or field placement in the 48-bit compare flips `dec_accept` for an exact-match address or for the edge of a masked window.
- A stuck or missing enable gate shows as an accept from a disabled entry, or a rejection right after the re-enable step of an update. Either is visible in the first frame sent a few receive cycles after the enable write.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int MCF_ENTRIES_DEF = 8;
  localparam int MCF_ADDR_W      = 48;
  localparam int MCF_LO_W        = 32;
  localparam int MCF_HI_W        = MCF_ADDR_W - MCF_LO_W;
  localparam int MCF_WORDS_PER   = 4;
  localparam int MCF_DST_BYTES   = MCF_ADDR_W / 8;
  localparam int MCF_CNT_W       = $clog2(MCF_DST_BYTES + 1);

  typedef struct packed {
    logic [MCF_ADDR_W-1:0] addr;
    logic [MCF_ADDR_W-1:0] mask;
  } mcf_entry_t;
endpackage

// File: rtl/mcf_rst_sync.sv
module mcf_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic stg_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      stg_q     <= 1'b0;
      rst_out_n <= 1'b0;
    end else begin
      stg_q     <= 1'b1;
      rst_out_n <= stg_q;
    end
  end
endmodule

// File: rtl/mcf_bit_sync.sv
module mcf_bit_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/mcf_regs.sv
module mcf_regs
  import mcf_pkg::*;
#(
  parameter int N  = MCF_ENTRIES_DEF,
  parameter int AW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [31:0]           wr_data,
  output logic [N-1:0]          en_q,
  output mcf_entry_t [N-1:0]    ent_q
);
  logic [N-1:0]       en_d;
  mcf_entry_t [N-1:0] ent_d;

  always_comb begin
    en_d  = en_q;
    ent_d = ent_q;
    if (wr_en) begin
      if (wr_addr == '0) en_d = wr_data[N-1:0];
      for (int n = 0; n < N; n++) begin
        if (wr_addr == AW'(1 + MCF_WORDS_PER*n))
          ent_d[n].addr[MCF_LO_W-1:0] = wr_data;
        if (wr_addr == AW'(2 + MCF_WORDS_PER*n))
          ent_d[n].addr[MCF_ADDR_W-1:MCF_LO_W] = wr_data[MCF_HI_W-1:0];
        if (wr_addr == AW'(3 + MCF_WORDS_PER*n))
          ent_d[n].mask[MCF_LO_W-1:0] = wr_data;
        if (wr_addr == AW'(4 + MCF_WORDS_PER*n))
          ent_d[n].mask[MCF_ADDR_W-1:MCF_LO_W] = wr_data[MCF_HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ent_q <= '0;
    end else if (wr_en) begin
      en_q  <= en_d;
      ent_q <= ent_d;
    end
  end
endmodule

// File: rtl/mcf_match.sv
module mcf_match
  import mcf_pkg::*;
#(
  parameter int N = MCF_ENTRIES_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          en,
  input  mcf_entry_t [N-1:0]    ent,
  input  logic                  rx_valid,
  input  logic                  rx_sof,
  input  logic                  rx_eof,
  input  logic [7:0]            rx_data,
  output logic                  dec_valid,
  output logic                  dec_accept,
  output logic                  byte_take,
  output logic [MCF_CNT_W-1:0]  byte_idx
);
  localparam int SH_W = MCF_ADDR_W - 8;
  localparam logic [MCF_CNT_W-1:0] LAST_IDX = MCF_CNT_W'(MCF_DST_BYTES - 1);
  localparam logic [MCF_CNT_W-1:0] DONE_CNT = MCF_CNT_W'(MCF_DST_BYTES);

  logic [MCF_CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]       sh_q, sh_d;
  logic                  live_q, live_d;
  logic                  dv_d, acc_d;
  logic                  decide, short_end;
  logic [MCF_ADDR_W-1:0] dest;
  logic [N-1:0]          hit;

  assign dest = {sh_q, rx_data};

  for (genvar n = 0; n < N; n++) begin : g_ent
    logic [MCF_ADDR_W-1:0] g_addr, g_mask;
    assign g_addr = ent[n].addr & {MCF_ADDR_W{en[n]}};
    assign g_mask = ent[n].mask & {MCF_ADDR_W{en[n]}};
    assign hit[n] = en[n] & ~|((dest ^ g_addr) & g_mask);
  end

  always_comb begin
    byte_idx  = rx_sof ? '0 : cnt_q;
    byte_take = rx_valid & (rx_sof | (live_q & (cnt_q < DONE_CNT)));
    decide    = byte_take & (byte_idx == LAST_IDX);
    short_end = byte_take & rx_eof & (byte_idx != LAST_IDX);
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    live_d = live_q;
    if (byte_take) begin
      cnt_d = byte_idx + 1'b1;
      sh_d  = {sh_q[SH_W-9:0], rx_data};
    end
    if (rx_valid) begin
      if (rx_sof)      live_d = ~rx_eof;
      else if (rx_eof) live_d = 1'b0;
    end
    dv_d  = decide | short_end;
    acc_d = decide & (|hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      sh_q       <= '0;
      live_q     <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      if (byte_take) begin
        cnt_q <= cnt_d;
        sh_q  <= sh_d;
      end
      if (rx_valid) live_q <= live_d;
      dec_valid  <= dv_d;
      dec_accept <= acc_d;
    end
  end
endmodule

// File: rtl/mcf_dst_filter.sv
module mcf_dst_filter
  import mcf_pkg::*;
#(
  parameter int NUM_ENTRIES = MCF_ENTRIES_DEF,
  parameter int REG_AW      = 6
) (
  input  logic              host_clk,
  input  logic              host_rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic                           host_rst_q;
  logic                           rx_rst_q;
  logic [NUM_ENTRIES-1:0]         en_host;
  logic [NUM_ENTRIES-1:0]         en_rx;
  mcf_entry_t [NUM_ENTRIES-1:0]   ent_host;
  logic                           byte_take;
  logic [MCF_CNT_W-1:0]           byte_idx;

  mcf_rst_sync u_host_rst (.clk(host_clk), .rst_in_n(host_rst_n), .rst_out_n(host_rst_q));
  mcf_rst_sync u_rx_rst   (.clk(rx_clk),   .rst_in_n(rx_rst_n),   .rst_out_n(rx_rst_q));

  mcf_regs #(.N(NUM_ENTRIES), .AW(REG_AW)) u_regs (
    .clk(host_clk), .rst_n(host_rst_q), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .en_q(en_host), .ent_q(ent_host)
  );

  mcf_bit_sync #(.W(NUM_ENTRIES)) u_en_sync (
    .clk(rx_clk), .rst_n(rx_rst_q), .d(en_host), .q(en_rx)
  );

  mcf_match #(.N(NUM_ENTRIES)) u_match (
    .clk(rx_clk), .rst_n(rx_rst_q), .en(en_rx), .ent(ent_host),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .byte_take(byte_take), .byte_idx(byte_idx)
  );
endmodule

// File: rtl/mcf_filter_chk.sv
module mcf_filter_chk #(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid,
  input logic          dec_accept,
  input logic          byte_take,
  input logic [CW-1:0] byte_idx,
  input logic          rx_eof,
  input logic [N-1:0]  en_rx
);
  // R7
  accept_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);
  // R7
  sixth_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && byte_idx == CW'(5)) |=> dec_valid);
  // R8
  short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && rx_eof && byte_idx != CW'(5)) |=> (dec_valid && !dec_accept));
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_take |=> !dec_valid);
  // R6
  all_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && byte_idx == CW'(5) && en_rx == '0) |=> !dec_accept);
endmodule

bind mcf_dst_filter mcf_filter_chk #(.N(NUM_ENTRIES), .CW(mcf_pkg::MCF_CNT_W)) u_chk (
  .clk(rx_clk), .rst_n(rx_rst_q), .dec_valid(dec_valid), .dec_accept(dec_accept),
  .byte_take(byte_take), .byte_idx(byte_idx), .rx_eof(rx_eof), .en_rx(en_rx)
);

// File: tb/tb_mcf_dst_filter.sv
module tb_mcf_dst_filter;
  logic        host_clk = 1'b0, rx_clk = 1'b0;
  logic        host_rst_n, rx_rst_n;
  logic        reg_wr_en;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic        dec_valid, dec_accept;

  int checks = 0, errors = 0, pulses = 0;
  logic [7:0] fb [0:23];

  always #10 host_clk = ~host_clk;
  always #8  rx_clk   = ~rx_clk;

  mcf_dst_filter dut (
    .host_clk(host_clk), .host_rst_n(host_rst_n), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  always @(negedge rx_clk) if (dec_valid === 1'b1) pulses++;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge host_clk);
    reg_wr_en = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge host_clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic prog(input int n, input logic [47:0] a, input logic [47:0] m);
    wr(1 + 4*n, a[31:0]);
    wr(2 + 4*n, {16'h0, a[47:32]});
    wr(3 + 4*n, m[31:0]);
    wr(4 + 4*n, {16'h0, m[47:32]});
  endtask

  task automatic set_en(input logic [7:0] v);
    wr(0, {24'h0, v});
    repeat (8) @(negedge rx_clk);
  endtask

  task automatic load(input logic [47:0] mac);
    for (int i = 0; i < 24; i++) fb[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 6; i++) fb[i] = mac[47 - 8*i -: 8];
  endtask

  task automatic idle_rx();
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
  endtask

  task automatic run_frame(input int n, input logic exp_acc, input string tag);
    int  p0;
    bit  due;
    p0  = pulses;
    due = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge rx_clk); #1;
      if (due) begin
        chk(32'(dec_valid), 1, {tag, " pulse timing R7"});
        chk(32'(dec_accept), 32'(exp_acc), {tag, " decision"});
        due = 0;
      end
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = fb[i];
      if (i == 5 || (n < 6 && i == n - 1)) due = 1;
    end
    @(negedge rx_clk); #1;
    if (due) begin
      chk(32'(dec_valid), 1, {tag, " pulse timing R7"});
      chk(32'(dec_accept), 32'(exp_acc), {tag, " decision"});
    end
    idle_rx();
    repeat (4) @(negedge rx_clk);
    chk(32'(pulses - p0), 1, {tag, " one pulse per frame R9"});
  endtask

  task automatic t_reset();
    chk(32'(dec_valid), 0, "R1 dec_valid low after reset");
    load(48'hAABB_CCDD_EEFF);
    run_frame(8, 1'b0, "R1 no entries enabled");
  endtask

  task automatic t_exact();
    prog(0, 48'hAABB_CCDD_EEFF, 48'hFFFF_FFFF_FFFF);
    set_en(8'h01);
    load(48'hAABB_CCDD_EEFF);
    run_frame(10, 1'b1, "R3 R2 exact match entry 0");
    load(48'hAABB_CCDD_EEFE);
    run_frame(10, 1'b0, "R3 last bit differs");
    load(48'h2ABB_CCDD_EEFF);
    run_frame(10, 1'b0, "R3 first byte msb differs");
  endtask

  task automatic t_mask();
    prog(4, 48'h0100_5E00_0000, 48'hFFFF_FFFF_FFF0);
    set_en(8'h10);
    load(48'h0100_5E00_0007);
    run_frame(6, 1'b1, "R4 window low half");
    load(48'h0100_5E00_000F);
    run_frame(7, 1'b1, "R4 window top");
    load(48'h0100_5E00_0010);
    run_frame(7, 1'b0, "R4 just outside window");
    load(48'hAABB_CCDD_EEFF);
    run_frame(8, 1'b0, "R6 programmed entry 0 disabled");
  endtask

  task automatic t_multi();
    prog(7, 48'h0200_0000_0001, 48'hFFFF_FFFF_FFFF);
    prog(1, 48'h1234_5678_9ABC, 48'h0);
    set_en(8'h91);
    load(48'hAABB_CCDD_EEFF);
    run_frame(8, 1'b1, "R5 entry 0 of several");
    load(48'h0100_5E00_0003);
    run_frame(8, 1'b1, "R5 entry 4 of several");
    load(48'h0200_0000_0001);
    run_frame(8, 1'b1, "R5 entry 7 of several");
    load(48'h0300_0000_0001);
    run_frame(8, 1'b0, "R5 no entry matches");
    set_en(8'h02);
    load(48'h7777_1111_2222);
    run_frame(8, 1'b1, "R4 zero mask accepts any");
  endtask

  task automatic t_short();
    set_en(8'h02);
    load(48'h0);
    run_frame(4, 1'b0, "R8 four-byte frame");
    run_frame(1, 1'b0, "R8 one-byte frame");
    run_frame(5, 1'b0, "R8 five-byte frame");
  endtask

  task automatic t_long();
    set_en(8'h01);
    load(48'hAABB_CCDD_EEFF);
    for (int i = 6; i < 24; i++) fb[i] = 8'hAA;
    run_frame(24, 1'b1, "R9 long frame single decision");
  endtask

  task automatic t_restart();
    int p0;
    set_en(8'h01);
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      @(negedge rx_clk); #1;
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = 1'b0; rx_data = 8'h55;
    end
    load(48'hAABB_CCDD_EEFF);
    run_frame(8, 1'b1, "R10 sof restarts count");
    chk(32'(pulses - p0), 1, "R10 partial frame gave no pulse");
  endtask

  task automatic t_update();
    set_en(8'h81);
    load(48'h0200_0000_0001);
    run_frame(8, 1'b1, "R11 old entry 7 before update");
    set_en(8'h01);
    prog(7, 48'h0200_0000_00A0, 48'hFFFF_FFFF_FFFF);
    set_en(8'h81);
    load(48'h0200_0000_0001);
    run_frame(8, 1'b0, "R11 old address gone");
    load(48'h0200_0000_00A0);
    run_frame(8, 1'b1, "R11 new address matches");
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    host_rst_n = 1'b0; rx_rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle_rx();
    repeat (4) @(negedge host_clk);
    host_rst_n = 1'b1; rx_rst_n = 1'b1;
    repeat (6) @(negedge rx_clk);
    t_reset();
    t_exact();
    t_mask();
    t_multi();
    t_short();
    t_long();
    t_restart();
    t_update();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule